// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block produces, once per clock, the address that a microprogrammed control unit presents to its control store. It keeps a control address register and a single-entry return register. The fields of the microinstruction currently being executed steer it: an address field, a condition selector and a two-bit branch code. It also reads a vector of status bits and an address that external logic derives from the opcode of the machine instruction.

A condition multiplexer reduces the status vector to one test bit. Selector value 0 stands for a constant true, which gives unconditional forms of jump and call. A small decoder turns the branch code and the test bit into a two-bit source select for the four-way address multiplexer and a save strobe for the return register. The four sources are the incremented address, the address field, the saved return address and the mapped opcode address. The control store and the decoding of the remaining microinstruction fields are outside the block.

Top module: `mseq_sequencer`

## Requirements
- R1: A synchronous active-high reset drives the address register and the return register to 0; the first return after reset therefore yields address 0.
- R2: Branch code 0 (jump) with the test bit at 1 loads the address field into the address register at the next rising edge.
- R3: Branch code 0 or 1 with the test bit at 0 loads the current address plus one.
- R4: Condition selector value 0 makes the test bit 1 whatever the status vector holds.
- R5: Condition selector value k from 1 up to the status width makes the test bit equal to status bit k-1.
- R6: Branch code 1 (call) with the test bit at 1 loads the address field and, at the same edge, stores the pre-branch address plus one in the return register.
- R7: The return register changes only on a taken call or on reset; a call that is not taken leaves it unchanged.
- R8: Branch code 2 (return) loads the return register's contents and leaves that register unchanged, so repeated returns land on the same address.
- R9: Branch code 3 (map) loads the external mapped address whatever the test bit is.
- R10: Incrementing wraps modulo 2^ADDR_W, so the all-ones address advances to 0, and a call made from it saves 0.
- R11: The return register holds one entry: a second taken call overwrites the address saved by the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_field | input | ADDR_W | Target address field of the current microinstruction |
| cond_sel | input | COND_W | Condition selector; 0 is constant true, k selects status bit k-1 |
| branch_code | input | 2 | 0 jump, 1 call, 2 return, 3 map |
| status | input | STAT_W | Status flags tested by the condition multiplexer |
| map_addr | input | ADDR_W | Address mapped from the machine instruction opcode |
| car | output | ADDR_W | Current control-store address |

## Verification
Directed sequences come first. They pair each branch code with a true and a false test bit, which separates a taken transfer from a fall-through increment. A return issued straight after reset tells a cleared return register from a stale one. Repeated returns and a not-taken call between a call and its return show whether the saved address is disturbed. A jump to the all-ones address followed by an increment and by a call checks the wrap. Two calls in a row show that the older return address is lost. A long random stream then mixes every selector, status pattern and branch code, so a selector that picks the wrong status bit or a swapped multiplexer input makes the address diverge from the cycle model.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [1:0] {
        SRC_INC   = 2'd0,
        SRC_FIELD = 2'd1,
        SRC_SAVED = 2'd2,
        SRC_MAP   = 2'd3
    } src_sel_e;

    typedef enum logic [1:0] {
        BR_JUMP   = 2'd0,
        BR_CALL   = 2'd1,
        BR_RETURN = 2'd2,
        BR_MAP    = 2'd3
    } branch_e;

    typedef struct packed {
        src_sel_e src;
        logic     save;
    } seq_ctrl_t;

    // Branch code plus test bit to multiplexer select and save strobe.
    function automatic seq_ctrl_t decode_branch(branch_e br, logic test);
        seq_ctrl_t c;
        c.src  = SRC_INC;
        c.save = 1'b0;
        unique case (br)
            BR_JUMP: begin
                c.src = test ? SRC_FIELD : SRC_INC;
            end
            BR_CALL: begin
                c.src  = test ? SRC_FIELD : SRC_INC;
                c.save = test;
            end
            BR_RETURN: c.src = SRC_SAVED;
            BR_MAP:    c.src = SRC_MAP;
            default:   c.src = SRC_INC;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mseq_cond_mux.sv
module mseq_cond_mux #(
    parameter int STAT_W = 7,
    parameter int COND_W = 3
) (
    input  logic [STAT_W-1:0] status,
    input  logic [COND_W-1:0] cond_sel,
    output logic              test
);
    localparam int NCAND = 1 << COND_W;

    logic [NCAND-1:0] cand;

    assign cand[0] = 1'b1;

    generate
        for (genvar i = 1; i < NCAND; i++) begin : g_cand
            if (i <= STAT_W) begin : g_flag
                assign cand[i] = status[i-1];
            end else begin : g_unused
                assign cand[i] = 1'b0;
            end
        end
    endgenerate

    assign test = cand[cond_sel];

endmodule

// File: rtl/mseq_branch_logic.sv
module mseq_branch_logic
    import mseq_pkg::*;
(
    input  logic [1:0] branch_code,
    input  logic       test,
    output seq_ctrl_t  ctrl
);
    always_comb begin
        ctrl = decode_branch(branch_e'(branch_code), test);
    end
endmodule

// File: rtl/mseq_addr_mux.sv
module mseq_addr_mux
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  src_sel_e             sel,
    input  logic [ADDR_W-1:0]    inc_addr,
    input  logic [ADDR_W-1:0]    field_addr,
    input  logic [ADDR_W-1:0]    saved_addr,
    input  logic [ADDR_W-1:0]    map_addr,
    output logic [ADDR_W-1:0]    next_addr
);
    localparam int NSRC = 4;

    logic [ADDR_W-1:0] srcs [NSRC];

    assign srcs[SRC_INC]   = inc_addr;
    assign srcs[SRC_FIELD] = field_addr;
    assign srcs[SRC_SAVED] = saved_addr;
    assign srcs[SRC_MAP]   = map_addr;

    assign next_addr = srcs[sel];

endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int STAT_W = 7,
    parameter int COND_W = $clog2(STAT_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_field,
    input  logic [COND_W-1:0] cond_sel,
    input  logic [1:0]        branch_code,
    input  logic [STAT_W-1:0] status,
    input  logic [ADDR_W-1:0] map_addr,
    output logic [ADDR_W-1:0] car
);
    logic [ADDR_W-1:0] car_q;
    logic [ADDR_W-1:0] sbr_q;
    logic [ADDR_W-1:0] car_inc;
    logic [ADDR_W-1:0] car_d;
    logic              test;
    seq_ctrl_t         ctrl;

    assign car_inc = car_q + ADDR_W'(1);

    mseq_cond_mux #(
        .STAT_W (STAT_W),
        .COND_W (COND_W)
    ) u_cond (
        .status   (status),
        .cond_sel (cond_sel),
        .test     (test)
    );

    mseq_branch_logic u_branch (
        .branch_code (branch_code),
        .test        (test),
        .ctrl        (ctrl)
    );

    mseq_addr_mux #(
        .ADDR_W (ADDR_W)
    ) u_mux (
        .sel        (ctrl.src),
        .inc_addr   (car_inc),
        .field_addr (addr_field),
        .saved_addr (sbr_q),
        .map_addr   (map_addr),
        .next_addr  (car_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            car_q <= '0;
            sbr_q <= '0;
        end else begin
            car_q <= car_d;
            if (ctrl.save) begin
                sbr_q <= car_inc;
            end
        end
    end

    assign car = car_q;

endmodule

// File: rtl/mseq_sequencer_chk.sv
module mseq_sequencer_chk #(
    parameter int ADDR_W = 7,
    parameter int STAT_W = 7,
    parameter int COND_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_field,
    input logic [COND_W-1:0] cond_sel,
    input logic [1:0]        branch_code,
    input logic [STAT_W-1:0] status,
    input logic [ADDR_W-1:0] map_addr,
    input logic [ADDR_W-1:0] car,
    input logic [ADDR_W-1:0] sbr
);
    logic taken;

    always_comb begin
        taken = (cond_sel == '0);
        for (int i = 1; i <= STAT_W; i++) begin
            if (int'(cond_sel) == i) taken = status[i-1];
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (car == '0) && (sbr == '0));

    a_r2_jump_taken: assert property (@(posedge clk) disable iff (rst)
        (branch_code == 2'd0) && taken |=> car == $past(addr_field));

    a_r3_fall_through: assert property (@(posedge clk) disable iff (rst)
        (branch_code[1] == 1'b0) && !taken |=> car == ADDR_W'($past(car) + ADDR_W'(1)));

    a_r6_call_saves: assert property (@(posedge clk) disable iff (rst)
        (branch_code == 2'd1) && taken
        |=> (car == $past(addr_field)) && (sbr == ADDR_W'($past(car) + ADDR_W'(1))));

    a_r7_saved_held: assert property (@(posedge clk) disable iff (rst)
        !((branch_code == 2'd1) && taken) |=> $stable(sbr));

    a_r8_return: assert property (@(posedge clk) disable iff (rst)
        (branch_code == 2'd2) |=> car == $past(sbr));

    a_r9_map: assert property (@(posedge clk) disable iff (rst)
        (branch_code == 2'd3) |=> car == $past(map_addr));

endmodule

bind mseq_sequencer mseq_sequencer_chk #(
    .ADDR_W (ADDR_W),
    .STAT_W (STAT_W),
    .COND_W (COND_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_field  (addr_field),
    .cond_sel    (cond_sel),
    .branch_code (branch_code),
    .status      (status),
    .map_addr    (map_addr),
    .car         (car),
    .sbr         (sbr_q)
);

// File: tb/mseq_sequencer_tb.sv
module mseq_sequencer_tb;
    localparam int AW = 7;
    localparam int SW = 7;
    localparam int CW = 3;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr_field = '0;
    logic [CW-1:0] cond_sel = '0;
    logic [1:0]    branch_code = 2'd0;
    logic [SW-1:0] status = '0;
    logic [AW-1:0] map_addr = '0;
    logic [AW-1:0] car;

    int checks = 0;
    int failures = 0;
    int ref_car = 0;
    int ref_ret = 0;

    always #10 clk = ~clk;

    mseq_sequencer u_dut (
        .clk         (clk),
        .rst         (rst),
        .addr_field  (addr_field),
        .cond_sel    (cond_sel),
        .branch_code (branch_code),
        .status      (status),
        .map_addr    (map_addr),
        .car         (car)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic step(input int af, input int cs, input int br,
                        input int st, input int ma, input string req);
        bit t;
        int nxt;
        addr_field  = AW'(af);
        cond_sel    = CW'(cs);
        branch_code = 2'(br);
        status      = SW'(st);
        map_addr    = AW'(ma);
        t = (cs == 0) ? 1'b1 : ((st >> (cs - 1)) & 1) == 1;
        nxt = (ref_car + 1) & MASK;
        if (br == 0) begin
            if (t) nxt = af & MASK;
        end else if (br == 1) begin
            if (t) begin
                ref_ret = (ref_car + 1) & MASK;
                nxt = af & MASK;
            end
        end else if (br == 2) begin
            nxt = ref_ret;
        end else begin
            nxt = ma & MASK;
        end
        ref_car = nxt;
        @(posedge clk);
        @(negedge clk);
        check(req, int'(car), ref_car);
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_car = 0;
        ref_ret = 0;
        check("R1", int'(car), 0);
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(3);
        // R1: return right after reset lands on 0
        step(9, 0, 2, 0, 0, "R1");
        check("R1", int'(car), 0);
        // R4, R2: unconditional jump
        step(5, 0, 0, 0, 0, "R4");
        check("R2", int'(car), 5);
        // R5, R2: status bit 2 set, selector 3
        step(20, 3, 0, 7'b0000100, 0, "R5");
        check("R5", int'(car), 20);
        // R5, R3: bit 2 clear, all others set -> increment
        step(60, 3, 0, 7'b1111011, 0, "R3");
        check("R3", int'(car), 21);
        // R5: highest selector picks bit 6
        step(33, 7, 0, 7'b1000000, 0, "R5");
        step(44, 7, 0, 7'b0111111, 0, "R5");
        // R6: call saves 35
        step(40, 0, 1, 0, 0, "R6");
        step(0, 1, 0, 0, 0, "R3");
        step(0, 2, 0, 0, 0, "R3");
        // R8: return and repeat
        step(0, 0, 2, 0, 0, "R8");
        check("R8", int'(car), 35);
        step(0, 0, 2, 0, 0, "R8");
        check("R8", int'(car), 35);
        // R7: not-taken call increments and keeps the saved address
        step(90, 4, 1, 7'b1110111, 0, "R7");
        check("R7", int'(car), 36);
        step(0, 0, 2, 0, 0, "R7");
        check("R7", int'(car), 35);
        // R9: map ignores a false test
        step(11, 5, 3, 0, 100, "R9");
        check("R9", int'(car), 100);
        // R10: wrap on increment and on a call from the top
        step(127, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 0, 0, "R10");
        check("R10", int'(car), 0);
        step(127, 0, 0, 0, 0, "R10");
        step(50, 0, 1, 0, 0, "R10");
        step(0, 0, 2, 0, 0, "R10");
        check("R10", int'(car), 0);
        // R11: second call overwrites the first
        step(10, 0, 0, 0, 0, "R2");
        step(70, 0, 1, 0, 0, "R6");
        step(80, 0, 1, 0, 0, "R11");
        step(0, 0, 2, 0, 0, "R11");
        check("R11", int'(car), 71);
        // R1: reset mid-run clears both registers
        step(30, 0, 1, 0, 0, "R6");
        do_reset(1);
        step(0, 0, 2, 0, 0, "R1");
        check("R1", int'(car), 0);
        // Mixed random stream, tagged by branch code
        for (int n = 0; n < 400; n++) begin
            int br;
            br = $urandom_range(0, 3);
            step($urandom_range(0, 127), $urandom_range(0, 7), br,
                 $urandom_range(0, 127), $urandom_range(0, 127),
                 br == 0 ? "R2" : br == 1 ? "R6" : br == 2 ? "R8" : "R9");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule